// File: doc/BRIEF.md
# Answer-to-Reset Byte Parser

This block sits behind the character receiver of a smart-card interface and takes the answer-to-reset one byte at a time, once the initial synchronisation character has been consumed and the bit convention has already been undone. Each strobed byte is classified against the nested presence maps carried by the format byte and by every protocol-chaining byte. The block reports each byte's class and group index one cycle later, and keeps a running XOR over the answer for the optional trailing check byte.

While parsing, it captures the first-group TA, TB and TC bytes and the second-group TA byte. It records the first offered protocol type and flags specific mode when a second-group TA is present. It also reports the historical byte count and whether a check byte is required. The parse ends with a sticky done flag or a sticky error flag with a cause code. An external timeout can stop an incomplete parse. In that case the number of bytes accepted so far tells the controller which position was awaited.

Top module: `atr_parser`

## Requirements
- R1: After reset, `done`, `err`, `cls_vld`, `tck_req` and every capture-present flag are 0, and `err_code`, `next_pos`, `first_proto` and `hist_count` are 0.
- R2: The first byte is the format byte (class code 0). Its upper nibble is the first presence map and its lower nibble is the historical count K (0..15), reported on `hist_count`.
- R3: In a presence map, byte bit 4 flags TA, bit 5 TB, bit 6 TC and bit 7 TD, and the present bytes arrive in that order. `cls_kind` uses the codes TA=1, TB=2, TC=3, TD=4, historical=5, check=6, and `cls_grp` gives the 1-based group index. Both are valid with `cls_vld` in the cycle after the strobe.
- R4: A TD byte's upper nibble is the presence map of the next group. A group without TD ends the interface bytes, and the K historical bytes follow.
- R5: `first_proto` is the low nibble of the first-group TD, or 0 if that byte is absent. `ta1`, `tb1`, `tc1` and `ta2` hold the first-group TA, TB and TC and the second-group TA, each with its own present flag. `specific_mode` equals the second-group TA present flag.
- R6: A check byte is expected (`tck_req`=1) exactly when some TD announces a nonzero type. When no check byte is expected, the parse completes after the last historical byte or the last interface byte.
- R7: When a check byte arrives, the XOR of all bytes from the format byte through the check byte must be 0x00. Otherwise `err` rises with `err_code`=3.
- R8: A TD whose type is below the type of the previous TD, or a first-group TD with type 15, raises `err` with `err_code`=1.
- R9: A byte strobed after MAX_LEN (default 32) bytes have been accepted, with the parse still incomplete, raises `err` with `err_code`=2. In that case `next_pos` stays at MAX_LEN.
- R10: `timeout` during an incomplete parse raises `err` with `err_code`=4, and `next_pos` keeps the number of bytes accepted. If `timeout` and a strobe arrive in the same cycle, `timeout` wins and the byte is not counted. After `done`, `timeout` has no effect.
- R11: Once `done` or `err` is set, it stays set until reset. Further strobes produce no `cls_vld` and change neither `next_pos` nor any captured output.
- R12: `done` rises in the cycle after the final byte of a well-formed answer and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Byte strobe |
| byte_data | input | 8 | Decoded answer byte |
| timeout | input | 1 | Abort request from an external timer |
| cls_vld | output | 1 | Classification of the last accepted byte is valid |
| cls_kind | output | 3 | Byte class code |
| cls_grp | output | GRP_W | Interface group index of the classified byte |
| done | output | 1 | Parse finished without error (sticky) |
| err | output | 1 | Parse failed (sticky) |
| err_code | output | 3 | Cause: 1 order, 2 length, 3 check, 4 timeout |
| next_pos | output | clog2(MAX_LEN+1) | Bytes accepted so far, i.e. next expected position |
| first_proto | output | 4 | First offered protocol type |
| specific_mode | output | 1 | Second-group TA seen |
| hist_count | output | 4 | Historical byte count K |
| tck_req | output | 1 | A check byte is required |
| ta1 | output | 8 | First-group TA value |
| ta1_vld | output | 1 | First-group TA present |
| tb1 | output | 8 | First-group TB value |
| tb1_vld | output | 1 | First-group TB present |
| tc1 | output | 8 | First-group TC value |
| tc1_vld | output | 1 | First-group TC present |
| ta2 | output | 8 | Second-group TA value |
| ta2_vld | output | 1 | Second-group TA present |

## Verification
The bench targets the answers whose length depends on decisions made late in the stream. One case announces type 0 in the first group and type 1 in the second, so a design that judged the check byte by the first protocol alone would finish one byte early. Another case contains interface bytes only with K=0, so a parser that always entered the historical phase would hang until the timeout. A chain of full groups runs past 32 bytes to catch an off-by-one in the length limit. Type-order faults test both the forbidden first-group type 15 and a falling type. A timeout is raised in the same cycle as a strobe, which a parser that counted that byte would get wrong. Randomly built answers, some with a corrupted check byte, exercise every map combination against a bench-side decoder.

// File: rtl/atr_pkg.sv
package atr_pkg;

   typedef enum logic [2:0] {
      BK_FMT  = 3'd0,
      BK_TA   = 3'd1,
      BK_TB   = 3'd2,
      BK_TC   = 3'd3,
      BK_TD   = 3'd4,
      BK_HIST = 3'd5,
      BK_TCK  = 3'd6
   } bkind_e;

   typedef enum logic [2:0] {
      FE_NONE    = 3'd0,
      FE_ORDER   = 3'd1,
      FE_LENGTH  = 3'd2,
      FE_CHECK   = 3'd3,
      FE_TIMEOUT = 3'd4
   } ferr_e;

   typedef enum logic [2:0] {
      WS_FMT,
      WS_IFACE,
      WS_HIST,
      WS_TCK,
      WS_DONE,
      WS_FAIL
   } wstate_e;

   // Lowest set bit of a presence map (TA first, TD last).
   function automatic logic [3:0] map_low(input logic [3:0] m);
      return m & (~m + 4'd1);
   endfunction

endpackage

// File: rtl/atr_xor_acc.sv
module atr_xor_acc #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] din,
   output logic         zero_with_din
);

   logic [W-1:0] acc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)  acc_q <= '0;
      else if (en) acc_q <= acc_q ^ din;
   end

   assign zero_with_din = ((acc_q ^ din) == '0);

endmodule

// File: rtl/atr_capture.sv
module atr_capture import atr_pkg::*; #(
   parameter int GRP_W = 4,
   parameter int NSLOT = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  bkind_e             kind,
   input  logic [GRP_W-1:0]   grp,
   input  logic [7:0]         din,
   output logic [NSLOT*8-1:0] val,
   output logic [NSLOT-1:0]   has
);

   // Slot table: 0 TA of group 1, 1 TB of group 1, 2 TC of group 1, 3 TA of group 2
   function automatic bkind_e slot_kind(input int i);
      case (i)
         1:       return BK_TB;
         2:       return BK_TC;
         default: return BK_TA;
      endcase
   endfunction

   function automatic int slot_grp(input int i);
      return (i == 3) ? 2 : 1;
   endfunction

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      localparam bkind_e           SK = slot_kind(s);
      localparam logic [GRP_W-1:0] SG = GRP_W'(slot_grp(s));
      logic [7:0] v_q;
      logic       h_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            v_q <= '0;
            h_q <= 1'b0;
         end else if (accept && kind == SK && grp == SG) begin
            v_q <= din;
            h_q <= 1'b1;
         end
      end
      assign val[s*8 +: 8] = v_q;
      assign has[s]        = h_q;
   end

endmodule

// File: rtl/atr_walker.sv
module atr_walker import atr_pkg::*; #(
   parameter  int MAX_LEN = 32,
   parameter  int GRP_W   = 4,
   localparam int IDX_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [7:0]       byte_data,
   input  logic             timeout,
   input  logic             chk_zero,
   output logic             accept,
   output bkind_e           kind,
   output logic [GRP_W-1:0] grp,
   output logic             cls_vld,
   output bkind_e           cls_kind,
   output logic [GRP_W-1:0] cls_grp,
   output logic             done,
   output logic             err,
   output ferr_e            err_code,
   output logic [IDX_W-1:0] next_pos,
   output logic [3:0]       first_proto,
   output logic [3:0]       hist_count,
   output logic             tck_req
);

   localparam logic [GRP_W-1:0] GRP_ONE = GRP_W'(1);
   localparam logic [GRP_W-1:0] GRP_TOP = {GRP_W{1'b1}};
   localparam logic [IDX_W-1:0] LEN_LIM = IDX_W'(MAX_LEN);

   wstate_e          st_q, st_n, after_if;
   logic [3:0]       map_q, map_n, low;
   logic [3:0]       k_q, k_n, hleft_q, last_t_q, fp_q, t_new;
   logic [GRP_W-1:0] grp_q, grp_n;
   logic [IDX_W-1:0] cnt_q;
   logic             need_q, need_n;
   ferr_e            code_q;
   logic             active, abort, take, over, bad_order;

   always_comb begin
      low = map_low(map_q);
      case (st_q)
         WS_FMT:   kind = BK_FMT;
         WS_IFACE: kind = low[0] ? BK_TA : low[1] ? BK_TB : low[2] ? BK_TC : BK_TD;
         WS_HIST:  kind = BK_HIST;
         default:  kind = BK_TCK;
      endcase
      active    = (st_q == WS_FMT) || (st_q == WS_IFACE) || (st_q == WS_HIST) || (st_q == WS_TCK);
      abort     = active && timeout;
      take      = active && byte_vld && !timeout;
      over      = take && (cnt_q == LEN_LIM);
      accept    = take && !over;
      t_new     = byte_data[3:0];
      bad_order = (kind == BK_TD) &&
                  (((grp_q == GRP_ONE) && (t_new == 4'hF)) || (t_new < last_t_q));
      map_n     = ((st_q == WS_FMT) || (kind == BK_TD)) ? byte_data[7:4] : (map_q & ~low);
      k_n       = (st_q == WS_FMT) ? byte_data[3:0] : k_q;
      need_n    = need_q | ((kind == BK_TD) && (t_new != 4'h0));
      grp_n     = ((kind == BK_TD) && (grp_q != GRP_TOP)) ? grp_q + GRP_ONE : grp_q;
      after_if  = (k_n != 4'h0) ? WS_HIST : (need_n ? WS_TCK : WS_DONE);
      st_n      = (map_n != 4'h0) ? WS_IFACE : after_if;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= WS_FMT;
         map_q    <= '0;
         k_q      <= '0;
         hleft_q  <= '0;
         last_t_q <= '0;
         fp_q     <= '0;
         grp_q    <= GRP_ONE;
         cnt_q    <= '0;
         need_q   <= 1'b0;
         code_q   <= FE_NONE;
         cls_vld  <= 1'b0;
         cls_kind <= BK_FMT;
         cls_grp  <= '0;
      end else begin
         cls_vld <= 1'b0;
         if (abort) begin
            st_q   <= WS_FAIL;
            code_q <= FE_TIMEOUT;
         end else if (over) begin
            st_q   <= WS_FAIL;
            code_q <= FE_LENGTH;
         end else if (accept) begin
            cnt_q    <= cnt_q + 1'b1;
            cls_vld  <= 1'b1;
            cls_kind <= kind;
            cls_grp  <= (st_q == WS_IFACE) ? grp_q : '0;
            case (st_q)
               WS_FMT, WS_IFACE: begin
                  if (bad_order) begin
                     st_q   <= WS_FAIL;
                     code_q <= FE_ORDER;
                  end else begin
                     st_q    <= st_n;
                     map_q   <= map_n;
                     k_q     <= k_n;
                     hleft_q <= k_n;
                     need_q  <= need_n;
                     grp_q   <= grp_n;
                     if (kind == BK_TD) begin
                        last_t_q <= t_new;
                        if (grp_q == GRP_ONE) fp_q <= t_new;
                     end
                  end
               end
               WS_HIST: begin
                  hleft_q <= hleft_q - 4'd1;
                  if (hleft_q == 4'd1) st_q <= need_q ? WS_TCK : WS_DONE;
               end
               default: begin
                  if (chk_zero) st_q <= WS_DONE;
                  else begin
                     st_q   <= WS_FAIL;
                     code_q <= FE_CHECK;
                  end
               end
            endcase
         end
      end
   end

   assign grp         = grp_q;
   assign done        = (st_q == WS_DONE);
   assign err         = (st_q == WS_FAIL);
   assign err_code    = code_q;
   assign next_pos    = cnt_q;
   assign first_proto = fp_q;
   assign hist_count  = k_q;
   assign tck_req     = need_q;

endmodule

// File: rtl/atr_parser.sv
module atr_parser import atr_pkg::*; #(
   parameter  int MAX_LEN = 32,
   parameter  int GRP_W   = 4,
   localparam int IDX_W   = $clog2(MAX_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld,
   input  logic [7:0]       byte_data,
   input  logic             timeout,
   output logic             cls_vld,
   output logic [2:0]       cls_kind,
   output logic [GRP_W-1:0] cls_grp,
   output logic             done,
   output logic             err,
   output logic [2:0]       err_code,
   output logic [IDX_W-1:0] next_pos,
   output logic [3:0]       first_proto,
   output logic             specific_mode,
   output logic [3:0]       hist_count,
   output logic             tck_req,
   output logic [7:0]       ta1,
   output logic             ta1_vld,
   output logic [7:0]       tb1,
   output logic             tb1_vld,
   output logic [7:0]       tc1,
   output logic             tc1_vld,
   output logic [7:0]       ta2,
   output logic             ta2_vld
);

   localparam int NSLOT = 4;

   if (MAX_LEN < 3 || MAX_LEN > 255) begin : g_bad_len
      $error("atr_parser: MAX_LEN must lie in 3..255");
   end
   if (GRP_W < 2) begin : g_bad_grp
      $error("atr_parser: GRP_W must be at least 2");
   end

   logic             accept, chk_zero;
   bkind_e           kind, cls_kind_e;
   ferr_e            code_e;
   logic [GRP_W-1:0] grp;
   logic [NSLOT*8-1:0] cap_val;
   logic [NSLOT-1:0]   cap_has;

   atr_walker #(.MAX_LEN(MAX_LEN), .GRP_W(GRP_W)) u_walk (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld    (byte_vld),
      .byte_data   (byte_data),
      .timeout     (timeout),
      .chk_zero    (chk_zero),
      .accept      (accept),
      .kind        (kind),
      .grp         (grp),
      .cls_vld     (cls_vld),
      .cls_kind    (cls_kind_e),
      .cls_grp     (cls_grp),
      .done        (done),
      .err         (err),
      .err_code    (code_e),
      .next_pos    (next_pos),
      .first_proto (first_proto),
      .hist_count  (hist_count),
      .tck_req     (tck_req)
   );

   atr_xor_acc #(.W(8)) u_xor (
      .clk           (clk),
      .rst_n         (rst_n),
      .en            (accept),
      .din           (byte_data),
      .zero_with_din (chk_zero)
   );

   atr_capture #(.GRP_W(GRP_W), .NSLOT(NSLOT)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .accept (accept),
      .kind   (kind),
      .grp    (grp),
      .din    (byte_data),
      .val    (cap_val),
      .has    (cap_has)
   );

   assign cls_kind      = cls_kind_e;
   assign err_code      = code_e;
   assign ta1           = cap_val[0  +: 8];
   assign tb1           = cap_val[8  +: 8];
   assign tc1           = cap_val[16 +: 8];
   assign ta2           = cap_val[24 +: 8];
   assign ta1_vld       = cap_has[0];
   assign tb1_vld       = cap_has[1];
   assign tc1_vld       = cap_has[2];
   assign ta2_vld       = cap_has[3];
   assign specific_mode = cap_has[3];

endmodule

// File: rtl/atr_parser_chk.sv
module atr_parser_chk #(
   parameter  int MAX_LEN = 32,
   parameter  int GRP_W   = 4,
   localparam int IDX_W   = $clog2(MAX_LEN + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             timeout,
   input logic             cls_vld,
   input logic [2:0]       cls_kind,
   input logic             done,
   input logic             err,
   input logic [2:0]       err_code,
   input logic [IDX_W-1:0] next_pos,
   input logic [3:0]       first_proto,
   input logic [3:0]       hist_count,
   input logic             tck_req
);

   // R11
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err && $stable(err_code));

   // R11
   done_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done && $stable(first_proto) && $stable(hist_count) && $stable(next_pos));

   // R11
   quiet_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> !cls_vld);

   // R12
   end_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R9
   pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      next_pos <= IDX_W'(MAX_LEN));

   // R6
   tck_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_vld && cls_kind == 3'd6) |-> tck_req);

   // R10
   timeout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !done && !err) |=> err && err_code == 3'd4 && $stable(next_pos));

endmodule

bind atr_parser atr_parser_chk #(.MAX_LEN(MAX_LEN), .GRP_W(GRP_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .timeout     (timeout),
   .cls_vld     (cls_vld),
   .cls_kind    (cls_kind),
   .done        (done),
   .err         (err),
   .err_code    (err_code),
   .next_pos    (next_pos),
   .first_proto (first_proto),
   .hist_count  (hist_count),
   .tck_req     (tck_req)
);

// File: tb/atr_parser_test.sv
module atr_parser_test;

   localparam int MAX_LEN = 32;
   localparam int GRP_W   = 4;
   localparam int IDX_W   = $clog2(MAX_LEN + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic byte_vld = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic timeout = 1'b0;
   logic cls_vld, done, err, specific_mode, tck_req;
   logic [2:0] cls_kind, err_code;
   logic [GRP_W-1:0] cls_grp;
   logic [IDX_W-1:0] next_pos;
   logic [3:0] first_proto, hist_count;
   logic [7:0] ta1, tb1, tc1, ta2;
   logic ta1_vld, tb1_vld, tc1_vld, ta2_vld;

   int checks = 0;
   int failures = 0;

   logic [7:0] seq [0:63];
   int n;
   int e_fp, e_k, e_tck, e_spec;
   int e_ta1, e_tb1, e_tc1, e_ta2;
   int e_ta1v, e_tb1v, e_tc1v;

   always #4 clk = ~clk;

   atr_parser #(.MAX_LEN(MAX_LEN), .GRP_W(GRP_W)) uut (.*);

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      chk(act == exp, req, what, act, exp);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; byte_vld = 1'b0; timeout = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      byte_vld = 1'b1; byte_data = b;
      @(negedge clk);
      byte_vld = 1'b0;
   endtask

   task automatic pulse_timeout();
      @(negedge clk);
      timeout = 1'b1;
      @(negedge clk);
      timeout = 1'b0;
   endtask

   // Bench model: builds a well-formed answer and its expected decode.
   task automatic build_valid();
      int ngrp, k, lastt, anyt, map, nmap, t;
      logic [7:0] x;
      n = 0; lastt = 0; anyt = 0;
      e_fp = 0; e_spec = 0; e_ta1v = 0; e_tb1v = 0; e_tc1v = 0;
      e_ta1 = 0; e_tb1 = 0; e_tc1 = 0; e_ta2 = 0;
      ngrp = 1 + int'($urandom % 3);
      k    = int'($urandom % 6);
      map  = int'($urandom % 8) | ((ngrp > 1) ? 8 : 0);
      seq[n++] = 8'(map * 16 + k);
      for (int g = 1; g <= ngrp; g++) begin
         if (map[0]) begin
            x = 8'($urandom); seq[n++] = x;
            if (g == 1) begin e_ta1 = x; e_ta1v = 1; end
            if (g == 2) begin e_ta2 = x; e_spec = 1; end
         end
         if (map[1]) begin
            x = 8'($urandom); seq[n++] = x;
            if (g == 1) begin e_tb1 = x; e_tb1v = 1; end
         end
         if (map[2]) begin
            x = 8'($urandom); seq[n++] = x;
            if (g == 1) begin e_tc1 = x; e_tc1v = 1; end
         end
         if (map[3]) begin
            nmap = int'($urandom % 8) | ((g + 1 < ngrp) ? 8 : 0);
            if (g == 1) begin
               case ($urandom % 3)
                  0: t = 0;
                  1: t = 1;
                  default: t = 14;
               endcase
               e_fp = t;
            end else begin
               t = lastt + int'($urandom % 2);
               if (t > 15) t = 15;
            end
            lastt = t;
            if (t != 0) anyt = 1;
            seq[n++] = 8'(nmap * 16 + t);
            map = nmap;
         end
      end
      for (int h = 0; h < k; h++) seq[n++] = 8'($urandom);
      e_k = k; e_tck = anyt;
      if (anyt != 0) begin
         x = 8'h00;
         for (int i = 0; i < n; i++) x = x ^ seq[i];
         seq[n++] = x;
      end
   endtask

   initial begin
      #(8 * 200000);
      failures++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      do_reset();

      // R1 reset state
      chk_eq("R1", "done", int'(done), 0);
      chk_eq("R1", "err", int'(err), 0);
      chk_eq("R1", "err_code", int'(err_code), 0);
      chk_eq("R1", "next_pos", int'(next_pos), 0);
      chk_eq("R1", "flags", int'({cls_vld, tck_req, ta1_vld, tb1_vld, tc1_vld, ta2_vld, first_proto, hist_count}), 0);

      // R2 R3 R4 R6: TA1 plus two historical bytes, no check byte
      send(8'h12);
      chk_eq("R2", "fmt class", int'(cls_kind), 0);
      chk_eq("R2", "hist_count", int'(hist_count), 2);
      send(8'h11);
      chk_eq("R3", "TA1 class", int'(cls_kind), 1);
      chk_eq("R3", "TA1 group", int'(cls_grp), 1);
      send(8'h41);
      chk_eq("R4", "hist class", int'(cls_kind), 5);
      chk_eq("R12", "done early", int'(done), 0);
      send(8'h42);
      chk_eq("R12", "done", int'(done), 1);
      chk_eq("R6", "tck_req", int'(tck_req), 0);
      chk_eq("R5", "ta1", int'(ta1), 8'h11);
      chk_eq("R5", "first_proto", int'(first_proto), 0);
      // R11 byte after done ignored; R10 timeout after done ignored
      send(8'h55);
      chk_eq("R11", "cls_vld after done", int'(cls_vld), 0);
      chk_eq("R11", "next_pos after done", int'(next_pos), 4);
      pulse_timeout();
      chk_eq("R10", "timeout after done", int'({done, err}), 2);

      // R6 R3: TD1 type 0, TD2 type 1, check byte required
      do_reset();
      send(8'h80);
      send(8'h80);
      chk_eq("R3", "TD1 class", int'(cls_kind), 4);
      chk_eq("R3", "TD1 group", int'(cls_grp), 1);
      send(8'h01);
      chk_eq("R3", "TD2 group", int'(cls_grp), 2);
      chk_eq("R6", "tck_req", int'(tck_req), 1);
      chk_eq("R12", "done before tck", int'(done), 0);
      send(8'h01);
      chk_eq("R7", "tck class", int'(cls_kind), 6);
      chk_eq("R7", "done good tck", int'(done), 1);

      // R7 bad check byte
      do_reset();
      send(8'h80); send(8'h80); send(8'h01); send(8'h00);
      chk_eq("R7", "bad tck code", int'({err, err_code}), 8 + 3);

      // R8 first-group type 15
      do_reset();
      send(8'h80); send(8'h0F);
      chk_eq("R8", "T15 in TD1", int'({err, err_code}), 8 + 1);
      chk_eq("R8", "pos at order fault", int'(next_pos), 2);
      send(8'h33);
      chk_eq("R11", "pos after err", int'(next_pos), 2);
      chk_eq("R11", "cls after err", int'(cls_vld), 0);

      // R8 falling type
      do_reset();
      send(8'h80); send(8'h81); send(8'h00);
      chk_eq("R8", "falling type", int'({err, err_code}), 8 + 1);

      // R9 overlong chain of full groups
      do_reset();
      send(8'hF0);
      for (int i = 1; i < MAX_LEN; i++) send((i % 4 == 0) ? 8'hF0 : 8'h00);
      chk_eq("R9", "no err at limit", int'(err), 0);
      chk_eq("R9", "pos at limit", int'(next_pos), MAX_LEN);
      send(8'h00);
      chk_eq("R9", "length code", int'({err, err_code}), 8 + 2);
      chk_eq("R9", "pos kept", int'(next_pos), MAX_LEN);

      // R10 timeout mid-parse
      do_reset();
      send(8'h13); send(8'hAA); send(8'h01);
      pulse_timeout();
      chk_eq("R10", "timeout code", int'({err, err_code}), 8 + 4);
      chk_eq("R10", "timeout pos", int'(next_pos), 3);

      // R10 timeout in the same cycle as a strobe
      do_reset();
      send(8'h13);
      @(negedge clk);
      byte_vld = 1'b1; byte_data = 8'hAA; timeout = 1'b1;
      @(negedge clk);
      byte_vld = 1'b0; timeout = 1'b0;
      chk_eq("R10", "strobe with timeout pos", int'(next_pos), 1);
      chk_eq("R10", "strobe with timeout code", int'(err_code), 4);

      // Random well-formed answers, some with corrupted check byte
      for (int r = 0; r < 80; r++) begin
         bit corrupt;
         do_reset();
         build_valid();
         corrupt = (e_tck != 0) && ($urandom % 4 == 0);
         if (corrupt) seq[n-1] = seq[n-1] ^ 8'h01;
         for (int i = 0; i < n; i++) begin
            if (i == n - 1) chk_eq("R12", "rnd done early", int'({done, err}), 0);
            send(seq[i]);
         end
         if (corrupt) begin
            chk_eq("R7", "rnd bad tck", int'({err, err_code}), 8 + 3);
         end else begin
            chk_eq("R12", "rnd done", int'({done, err}), 2);
            chk_eq("R4", "rnd next_pos", int'(next_pos), n);
            chk_eq("R2", "rnd hist", int'(hist_count), e_k);
            chk_eq("R6", "rnd tck_req", int'(tck_req), e_tck);
            chk_eq("R5", "rnd first_proto", int'(first_proto), e_fp);
            chk_eq("R5", "rnd specific", int'(specific_mode), e_spec);
            chk_eq("R5", "rnd ta1", int'({ta1_vld, ta1}), e_ta1v * 256 + e_ta1);
            chk_eq("R5", "rnd tb1", int'({tb1_vld, tb1}), e_tb1v * 256 + e_tb1);
            chk_eq("R5", "rnd tc1", int'({tc1_vld, tc1}), e_tc1v * 256 + e_tc1);
            chk_eq("R5", "rnd ta2", int'({ta2_vld, ta2}), e_spec * 256 + e_ta2);
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule